// File: doc/BRIEF.md
# Serial EEPROM Read Target (128 x 8)

This block is a two-wire bus target that behaves like a small serial EEPROM of 128 bytes. It concentrates on the read side. A fast system clock samples SCL and SDA. The block finds Start, repeated Start and Stop conditions and decodes the control byte that follows a Start. A 7-bit address pointer persists between transactions and sets where every read begins.

A master can use three read modes. A current-address read fetches the byte at the pointer. A random read first runs a dummy write that only loads the pointer, then a repeated Start switches to reading. A sequential read goes on returning bytes for as long as the master acknowledges them. The pointer wraps from the top of the array back to zero.

The write path goes only far enough to load the pointer and to store one optional data byte. The contents come from a register array that reset fills with a computed pattern. SDA is driven open-drain: the output is an enable that pulls the line low.

Top module: `eeprom_read_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), the pointer is 0, and the byte at address i reads as `FILL ^ i` (FILL defaults to 8'h5A).
- R2: A control byte is accepted only when its upper nibble equals DEV_CODE (default 4'b1010). Bit 0 is R/W (1 = read) and bits 3:1 are ignored. If the nibble does not match, no ACK is given and the target ignores every following byte until the next Start.
- R3: A current-address read returns the byte at the pointer, which is one past the last byte read or written.
- R4: A dummy write (control byte with R/W = 0, then a word address whose bit 7 is ignored) loads the pointer. A repeated Start then ends it without changing memory, and the read that follows returns the byte at that address.
- R5: While the master ACKs each data byte, the target sends the next byte in address order. The pointer wraps from 0x7F to 0x00, so the whole array can stream out in one transaction.
- R6: After a master NACK the target releases SDA and sends nothing more. The pointer is left one past the last byte sent.
- R7: In a write, the byte after the word address is stored at the pointer and the pointer then increments. A Stop right after the word address leaves memory unchanged and the pointer equal to that address.
- R8: In a write, any byte after the first data byte is not ACKed and is not stored.
- R9: A high `sda_oe` pulls SDA low. `sda_oe` changes only while the synchronized SCL is low. Data goes out MSB first, and each ACK is a low level during the ninth SCL pulse.
- R10: A Start or a Stop is recognized in any state. A Start in the middle of a byte discards the partial byte and begins a new control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
A pointer that drifts shows up at once as a wrong byte on the next read. The bench therefore follows every random read with a current-address read and streams across the wrap point. A state machine that is out of step shows up as a missing or extra ACK within the ninth pulse of the affected byte, or as SDA held low after a NACK. Each ACK slot and each data bit is sampled on its own. Memory changes are observed only through later reads of the exact addresses that were touched and of their neighbours.

// File: rtl/eeprom_read_target.sv
module eeprom_read_target #(
  parameter int          AW       = 7,
  parameter logic [3:0]  DEV_CODE = 4'b1010,
  parameter logic [7:0]  FILL     = 8'h5A
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, RX, RX_ACK, TX, TX_ACK} st_t;
  typedef enum logic [1:0] {K_CTRL, K_ADDR, K_DATA, K_DONE} kind_t;

  logic [2:0]    scl_p, sda_p;
  st_t           st;
  kind_t         kind;
  logic [3:0]    cnt;
  logic [7:0]    sr;
  logic [AW-1:0] ptr;
  logic          rd, mack;
  logic [7:0]    mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  wire scl_rise = scl_p[1] & ~scl_p[2];
  wire scl_fall = ~scl_p[1] & scl_p[2];
  wire start    = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire stop     = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire byte_in  = (st == RX) && scl_fall && (cnt == 4'd8);
  wire ld       = !start && !stop && scl_fall &&
                  (((st == RX_ACK) && rd) || ((st == TX_ACK) && mack));
  wire [7:0] cur = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; kind <= K_CTRL; cnt <= '0; sr <= '0; ptr <= '0;
      rd <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= FILL ^ 8'(i);
    end else if (start) begin
      st <= RX; kind <= K_CTRL; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        RX:
          if (scl_rise && cnt != 4'd8) begin
            sr  <= {sr[6:0], sda_p[1]};
            cnt <= cnt + 4'd1;
          end else if (byte_in) begin
            cnt <= '0;
            case (kind)
              K_CTRL:
                if (sr[7:4] == DEV_CODE) begin
                  rd <= sr[0]; sda_oe <= 1'b1; st <= RX_ACK;
                end else st <= IDLE;
              K_ADDR: begin ptr <= sr[AW-1:0]; sda_oe <= 1'b1; st <= RX_ACK; end
              K_DATA: begin
                mem[ptr] <= sr; ptr <= ptr + 1'b1; sda_oe <= 1'b1; st <= RX_ACK;
              end
              default: st <= IDLE;
            endcase
          end
        RX_ACK:
          if (scl_fall && !rd) begin
            sda_oe <= 1'b0;
            st     <= RX;
            kind   <= (kind == K_CTRL) ? K_ADDR : (kind == K_ADDR) ? K_DATA : K_DONE;
          end
        TX:
          if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0; st <= TX_ACK;
            end else begin
              sda_oe <= ~sr[6];
              sr     <= {sr[6:0], 1'b0};
              cnt    <= cnt + 4'd1;
            end
          end
        TX_ACK:
          if (scl_rise) mack <= ~sda_p[1];
          else if (scl_fall && !mack) st <= IDLE;
        default: ;
      endcase
      if (ld) begin
        sr <= cur; sda_oe <= ~cur[7]; ptr <= ptr + 1'b1; cnt <= '0; st <= TX;
      end
    end

  // R9
  oe_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_p[1]);
  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && ptr == {AW{1'b1}}) |=> (ptr == '0));
  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!sda_oe && st == IDLE));
  // R2
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && kind == K_CTRL && sr[7:4] != DEV_CODE && !start && !stop)
      |=> (!sda_oe && st == IDLE));
  // R10
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == RX && kind == K_CTRL && cnt == '0));
  // R8
  extra_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_in && kind == K_DONE && !start && !stop) |=> !sda_oe);
endmodule

// File: tb/eeprom_read_target_test.sv
`timescale 1ns/1ps
module eeprom_read_target_test;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   tests = 0, failed = 0;
  bit   done = 1'b0;
  logic [7:0] em [128];
  int   eptr;

  always #2.5 clk = ~clk;

  eeprom_read_target uut (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe));

  task automatic hq; repeat (Q) @(posedge clk); #1; endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin failed++; $display("FAIL %s: got %0h expected %0h", tag, act, exp); end
  endtask

  task automatic bus_start; sda_m = 1; hq; scl_m = 1; hq; sda_m = 0; hq; scl_m = 0; hq; endtask
  task automatic bus_stop;  sda_m = 0; hq; scl_m = 1; hq; sda_m = 1; hq; endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hq; scl_m = 1; hq; hq; scl_m = 0; hq;
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1; hq; scl_m = 1; hq; acked = ~sda_line; hq; scl_m = 0; hq;
  endtask

  task automatic rd_byte(input bit ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      hq; scl_m = 1; hq; b[i] = sda_line; hq; scl_m = 0;
    end
    hq; sda_m = ack ? 1'b0 : 1'b1; hq; scl_m = 1; hq; hq; scl_m = 0; hq; sda_m = 1;
  endtask

  task automatic wr_ack(input logic [7:0] b, input bit exp, input string tag);
    bit a;
    wr_byte(b, a);
    chk(a == exp, tag, a, exp);
  endtask

  task automatic cur_read(input string tag);
    logic [7:0] d;
    bus_start; wr_ack(8'hA1, 1, "R2/R9 ack");
    rd_byte(0, d); bus_stop;
    chk(d == em[eptr], tag, d, em[eptr]);
    eptr = (eptr + 1) % 128;
  endtask

  task automatic rand_read(input int a, input string tag);
    logic [7:0] d;
    bus_start; wr_ack(8'hA0, 1, "R2/R9 ack"); wr_ack(8'(a), 1, "R4 addr ack");
    bus_start; wr_ack(8'hA1, 1, "R4 ack");
    rd_byte(0, d); bus_stop;
    chk(d == em[a], tag, d, em[a]);
    eptr = (a + 1) % 128;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failed++; tests++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 128; i++) em[i] = 8'h5A ^ 8'(i);
    eptr = 0;
    repeat (5) @(posedge clk); #1;
    chk(sda_oe == 0, "R1 released in reset", sda_oe, 0);
    rst_n = 1; hq;
    chk(sda_oe == 0, "R1 released after reset", sda_oe, 0);
    cur_read("R1 first read at 0");

    // R2: select bits ignored
    bus_start; wr_ack(8'hAB, 1, "R2 select bits ignored");
    rd_byte(0, d); bus_stop;
    chk(d == em[eptr], "R2 data", d, em[eptr]); eptr++;

    // R2: wrong type code, following bytes ignored
    bus_start; wr_ack(8'h91, 0, "R2 wrong code no ack");
    wr_ack(8'h00, 0, "R2 ignored until start"); bus_stop;
    cur_read("R2 pointer untouched");

    // R4 random reads then R3 current reads
    for (int a = 0; a < 128; a += 9) begin
      rand_read(a, "R4 random read");
      cur_read("R3 current read follows");
    end
    rand_read(127, "R4 random read top");
    cur_read("R5 current read wraps");

    // R5 sequential across wrap
    bus_start; wr_ack(8'hA0, 1, "R2 ack"); wr_ack(8'h7C, 1, "R4 addr ack");
    bus_start; wr_ack(8'hA1, 1, "R2 ack");
    eptr = 8'h7C;
    for (int k = 0; k < 132; k++) begin
      rd_byte(k != 131, d);
      chk(d == em[eptr], "R5/R9 sequential", d, em[eptr]);
      eptr = (eptr + 1) % 128;
    end
    bus_stop;
    chk(sda_oe == 0, "R6 released after nack", sda_oe, 0);
    cur_read("R6 pointer after nack");

    // R7 write one byte
    bus_start; wr_ack(8'hA0, 1, "R7 ack"); wr_ack(8'h10, 1, "R7 addr ack");
    wr_ack(8'hC3, 1, "R7 data ack"); bus_stop;
    em[8'h10] = 8'hC3; eptr = 8'h11;
    cur_read("R7 pointer after write");
    rand_read(8'h10, "R7 stored byte");

    // R7 address only
    bus_start; wr_ack(8'hA0, 1, "R7 ack"); wr_ack(8'hA0, 1, "R7 addr ack"); bus_stop;
    eptr = 8'h20;
    cur_read("R7 address only, bit7 ignored");

    // R8 second data byte refused
    bus_start; wr_ack(8'hA0, 1, "R8 ack"); wr_ack(8'h30, 1, "R8 addr ack");
    wr_ack(8'h11, 1, "R8 first data ack"); wr_ack(8'h22, 0, "R8 second data nack");
    bus_stop;
    em[8'h30] = 8'h11;
    rand_read(8'h31, "R8 neighbour unchanged");
    rand_read(8'h30, "R8 first byte stored");

    // R10 start mid byte
    bus_start; wr_ack(8'hA0, 1, "R10 ack"); send_bits(8'h40, 3);
    bus_start; wr_ack(8'hA1, 1, "R10 ack after restart");
    rd_byte(0, d); bus_stop;
    chk(d == em[eptr], "R10 partial byte discarded", d, em[eptr]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule